// File: doc/BRIEF.md
# Bufferless Deflection Router with Two-Stage Swap Network

This block is one node router of a two-dimensional mesh network-on-chip. It holds no flit storage apart from the register stage at its outputs. Every flit that arrives on one of the four neighbour links in a cycle leaves on some neighbour link, or on the local ejection port, one clock edge later. A flit that cannot have the output that brings it closer to its destination is deflected onto another free output and is never dropped or held back.

Output ports are assigned by two levels of 2x2 arbitrating swap elements. The first level decides which half of the outputs each flit goes to. The second level picks the port inside that half. In each element the older flit steers the swap toward its own preferred port. Before the network, the oldest flit addressed to this node is taken out for ejection. The local core may then place one new flit into an unused input slot.

The node position is fixed by the parameters `NODE_X` and `NODE_Y`. Ages grow by one at every hop, so a flit that has been deflected many times gains priority over newer traffic.

Top module: `defl_router`

## Requirements
- R1: While `rstN` is low, every `linkOut` flit has its valid bit cleared and `ejValid` is low.
- R2: The number of valid flits leaving is always equal to the number entering. The sum of valid `linkOut` flits plus `ejValid` after an edge equals the number of valid `linkIn` flits before it, plus one if an injection was accepted.
- R3: Output ports are numbered 0 = north (+Y), 1 = east (+X), 2 = south (-Y), 3 = west (-X). The preferred port is chosen X first. The flit goes east if the destination X is greater than the node X and west if it is smaller. When the X values are equal, it goes north if the destination Y is greater and south if it is smaller. A lone flit leaves on that port.
- R4: Priority goes to the larger age, and between equal ages to the smaller source ID. The flit with the highest priority in the network that cycle always leaves on its preferred port.
- R5: Among the valid link flits whose destination equals the node, exactly one is ejected. It is the one with the highest priority, and between full ties the one on the lower port index. It appears on `ejFlit` one edge later with all fields unchanged, including the age. Any other flits addressed to the node stay on neighbour links. Injected flits cannot be ejected.
- R6: `injReady` is high exactly when fewer than four link flits are valid in the current cycle. An accepted injection leaves on a link one edge later with age 1 and its destination, source and payload unchanged.
- R7: A flit on a neighbour output has an age one higher than at its input. The age saturates at 15, so a flit that enters with age 15 leaves with age 15.
- R8: A flit is 23 bits wide: valid [22], destination X [21:19], destination Y [18:16], source ID [15:12], age [11:8], payload [7:0]. Apart from the age, every field of a flit that passes through the router leaves unchanged. The injection request is 18 bits wide: destination X [17:15], destination Y [14:12], source ID [11:8], payload [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkIn | input | 4x23 | Flits arriving from the neighbours, indexed by port number |
| injValid | input | 1 | Local core offers a flit |
| injFlit | input | 18 | Injection request: destination, source and payload |
| injReady | output | 1 | Injection accepted this cycle if offered |
| linkOut | output | 4x23 | Registered flits leaving toward the neighbours |
| ejValid | output | 1 | Registered ejected flit is present |
| ejFlit | output | 23 | Registered flit delivered to the local core |

## Verification
`injReady` depends only on the current link inputs, so it is due in the same cycle. The bench reads it one nanosecond after it drives the inputs on the falling edge. Every other result passes through exactly one register: the neighbour outputs, the ejected flit and the aged fields all change at the next rising edge. The bench therefore stores its expectations when it drives a stimulus and compares them one nanosecond after that edge, before the next stimulus is applied. Each payload is unique within a cycle, so flits can be matched without knowing where the design routed them. The port-priority check is skipped only when two candidates are fully tied on age and source.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int COORD_W = 3;
  localparam int SRC_W   = 4;
  localparam int AGE_W   = 4;
  localparam int PAY_W   = 8;
  localparam int NPORT   = 4;
  localparam int IDX_W   = $clog2(NPORT);

  localparam logic [1:0] PORT_N = 2'd0;
  localparam logic [1:0] PORT_E = 2'd1;
  localparam logic [1:0] PORT_S = 2'd2;
  localparam logic [1:0] PORT_W = 2'd3;

  typedef struct packed {
    logic               valid;
    logic [COORD_W-1:0] dstX;
    logic [COORD_W-1:0] dstY;
    logic [SRC_W-1:0]   src;
    logic [AGE_W-1:0]   age;
  } hdr_t;

  typedef struct packed {
    hdr_t             hdr;
    logic [PAY_W-1:0] payload;
  } flit_t;

  typedef struct packed {
    logic [COORD_W-1:0] dstX;
    logic [COORD_W-1:0] dstY;
    logic [SRC_W-1:0]   src;
  } injHdr_t;

  typedef struct packed {
    injHdr_t          hdr;
    logic [PAY_W-1:0] payload;
  } injReq_t;

  localparam int FLIT_W = $bits(flit_t);
  localparam int INJ_W  = $bits(injReq_t);

  // arbitration view of one flit
  typedef struct packed {
    logic             valid;
    logic             pref;
    logic [AGE_W-1:0] age;
    logic [SRC_W-1:0] src;
  } meta_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0] ejSel;
    logic [NPORT-1:0] injSel;
    logic [1:0]       swapS1;
    logic [1:0]       swapS2;
  } steer_t;

  function automatic logic ageSrcBeats(logic [AGE_W-1:0] ageA, logic [SRC_W-1:0] srcA,
                                       logic [AGE_W-1:0] ageB, logic [SRC_W-1:0] srcB);
    return (ageA > ageB) || ((ageA == ageB) && (srcA < srcB));
  endfunction
endpackage

// File: rtl/defl_swap_arb.sv
module defl_swap_arb
  import defl_pkg::*;
(
  input  meta_t inA,
  input  meta_t inB,
  input  logic  wantA,
  input  logic  wantB,
  output logic  swap
);
  logic aWins;
  logic chooserIsA;
  logic chooserWant;
  logic haveChooser;

  always_comb begin
    // A keeps the win unless B is strictly better
    aWins = !(inB.valid && (!inA.valid ||
              ageSrcBeats(inB.age, inB.src, inA.age, inA.src)));
    haveChooser = 1'b0;
    chooserIsA  = 1'b1;
    chooserWant = 1'b0;
    if (aWins && inA.valid && inA.pref) begin
      haveChooser = 1'b1; chooserIsA = 1'b1; chooserWant = wantA;
    end else if (!aWins && inB.pref) begin
      haveChooser = 1'b1; chooserIsA = 1'b0; chooserWant = wantB;
    end else if (aWins && inB.valid && inB.pref) begin
      haveChooser = 1'b1; chooserIsA = 1'b0; chooserWant = wantB;
    end else if (!aWins && inA.valid && inA.pref) begin
      haveChooser = 1'b1; chooserIsA = 1'b1; chooserWant = wantA;
    end
    // A sits on the low output unless swapped
    if (!haveChooser) swap = 1'b0;
    else if (chooserIsA) swap = chooserWant;
    else swap = !chooserWant;
  end
endmodule

// File: rtl/defl_ctrl.sv
module defl_ctrl
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] NODE_X = '0,
  parameter logic [COORD_W-1:0] NODE_Y = '0
) (
  input  hdr_t [NPORT-1:0] arrHdr,
  input  logic             injValid,
  input  injHdr_t          injHdr,
  output logic             injReady,
  output steer_t           steer
);
  logic [NPORT-1:0] arrived, localHit, ejSel, injSel;
  hdr_t [NPORT-1:0] slotHdr;
  meta_t [NPORT-1:0] slotMeta;
  logic [NPORT-1:0][1:0] slotPort;
  meta_t [1:0][1:0] s1Meta;
  logic [1:0][1:0][1:0] s1Port;
  logic [1:0] swap1, swap2;

  logic ejFound;
  logic [IDX_W-1:0] ejIdx;
  hdr_t ejBest;
  logic injTaken;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      arrived[i]  = arrHdr[i].valid;
      localHit[i] = arrHdr[i].valid && (arrHdr[i].dstX == NODE_X) && (arrHdr[i].dstY == NODE_Y);
    end
  end

  // oldest local flit is pulled out before the network
  always_comb begin
    ejSel = '0; ejFound = 1'b0; ejIdx = '0; ejBest = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (localHit[i] && (!ejFound ||
          ageSrcBeats(arrHdr[i].age, arrHdr[i].src, ejBest.age, ejBest.src))) begin
        ejFound = 1'b1;
        ejIdx   = IDX_W'(i);
        ejBest  = arrHdr[i];
      end
    end
    if (ejFound) ejSel[ejIdx] = 1'b1;
  end

  assign injReady = ~&arrived;

  always_comb begin
    injSel = '0; injTaken = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (!arrived[i] && !injTaken && injValid && injReady) begin
        injSel[i] = 1'b1;
        injTaken  = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      if (injSel[i]) begin
        slotHdr[i].valid = 1'b1;
        slotHdr[i].dstX  = injHdr.dstX;
        slotHdr[i].dstY  = injHdr.dstY;
        slotHdr[i].src   = injHdr.src;
        slotHdr[i].age   = '0;
      end else if (ejSel[i]) begin
        slotHdr[i] = '0;
      end else begin
        slotHdr[i] = arrHdr[i];
      end
    end
  end

  // X-first productive port
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      slotMeta[i].valid = slotHdr[i].valid;
      slotMeta[i].age   = slotHdr[i].age;
      slotMeta[i].src   = slotHdr[i].src;
      slotMeta[i].pref  = 1'b1;
      if (slotHdr[i].dstX > NODE_X)      slotPort[i] = PORT_E;
      else if (slotHdr[i].dstX < NODE_X) slotPort[i] = PORT_W;
      else if (slotHdr[i].dstY > NODE_Y) slotPort[i] = PORT_N;
      else if (slotHdr[i].dstY < NODE_Y) slotPort[i] = PORT_S;
      else begin
        slotPort[i] = PORT_N;
        slotMeta[i].pref = 1'b0;
      end
    end
  end

  // level one: pick the half (port bit 1)
  for (genvar k = 0; k < 2; k++) begin : g_lvl1
    defl_swap_arb u_arb (
      .inA  (slotMeta[2*k]),
      .inB  (slotMeta[2*k+1]),
      .wantA(slotPort[2*k][1]),
      .wantB(slotPort[2*k+1][1]),
      .swap (swap1[k])
    );
    assign s1Meta[k][0] = swap1[k] ? slotMeta[2*k+1] : slotMeta[2*k];
    assign s1Meta[k][1] = swap1[k] ? slotMeta[2*k]   : slotMeta[2*k+1];
    assign s1Port[k][0] = swap1[k] ? slotPort[2*k+1] : slotPort[2*k];
    assign s1Port[k][1] = swap1[k] ? slotPort[2*k]   : slotPort[2*k+1];
  end

  // level two: pick the port inside the half (port bit 0)
  for (genvar g = 0; g < 2; g++) begin : g_lvl2
    defl_swap_arb u_arb (
      .inA  (s1Meta[0][g]),
      .inB  (s1Meta[1][g]),
      .wantA(s1Port[0][g][0]),
      .wantB(s1Port[1][g][0]),
      .swap (swap2[g])
    );
  end

  assign steer.ejSel  = ejSel;
  assign steer.injSel = injSel;
  assign steer.swapS1 = swap1;
  assign steer.swapS2 = swap2;
endmodule

// File: rtl/defl_datapath.sv
module defl_datapath
  import defl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flit_t [NPORT-1:0] arrIn,
  input  injReq_t           injReq,
  input  steer_t            steer,
  output flit_t [NPORT-1:0] outFlit,
  output logic              ejValid,
  output flit_t             ejFlit
);
  flit_t [NPORT-1:0] slot;
  flit_t [1:0][1:0]  lvl1;
  flit_t [NPORT-1:0] lvl2;
  flit_t             ejPick;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      if (steer.injSel[i]) begin
        slot[i].hdr.valid = 1'b1;
        slot[i].hdr.dstX  = injReq.hdr.dstX;
        slot[i].hdr.dstY  = injReq.hdr.dstY;
        slot[i].hdr.src   = injReq.hdr.src;
        slot[i].hdr.age   = '0;
        slot[i].payload   = injReq.payload;
      end else if (steer.ejSel[i]) begin
        slot[i] = '0;
      end else begin
        slot[i] = arrIn[i];
      end
    end
  end

  always_comb begin
    ejPick = '0;
    for (int i = 0; i < NPORT; i++)
      if (steer.ejSel[i]) ejPick = arrIn[i];
  end

  for (genvar k = 0; k < 2; k++) begin : g_mux1
    assign lvl1[k][0] = steer.swapS1[k] ? slot[2*k+1] : slot[2*k];
    assign lvl1[k][1] = steer.swapS1[k] ? slot[2*k]   : slot[2*k+1];
  end

  for (genvar g = 0; g < 2; g++) begin : g_mux2
    assign lvl2[2*g]   = steer.swapS2[g] ? lvl1[1][g] : lvl1[0][g];
    assign lvl2[2*g+1] = steer.swapS2[g] ? lvl1[0][g] : lvl1[1][g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outFlit <= '0;
      ejValid <= 1'b0;
      ejFlit  <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        outFlit[p] <= lvl2[p];
        if (lvl2[p].hdr.valid && (lvl2[p].hdr.age != '1))
          outFlit[p].hdr.age <= lvl2[p].hdr.age + 1'b1;
      end
      ejValid <= |steer.ejSel;
      ejFlit  <= ejPick;
    end
  end
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] NODE_X = 3'd3,
  parameter logic [COORD_W-1:0] NODE_Y = 3'd4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NPORT-1:0][FLIT_W-1:0] linkIn,
  input  logic                        injValid,
  input  logic [INJ_W-1:0]            injFlit,
  output logic                        injReady,
  output logic [NPORT-1:0][FLIT_W-1:0] linkOut,
  output logic                        ejValid,
  output logic [FLIT_W-1:0]           ejFlit
);
  flit_t [NPORT-1:0] arrIn;
  hdr_t  [NPORT-1:0] arrHdr;
  flit_t [NPORT-1:0] outFlit;
  flit_t             ejOut;
  injReq_t           injReq;
  steer_t            steer;

  assign arrIn  = linkIn;
  assign injReq = injFlit;
  for (genvar i = 0; i < NPORT; i++) begin : g_hdr
    assign arrHdr[i] = arrIn[i].hdr;
  end

  defl_ctrl #(.NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_ctrl (
    .arrHdr  (arrHdr),
    .injValid(injValid),
    .injHdr  (injReq.hdr),
    .injReady(injReady),
    .steer   (steer)
  );

  defl_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .arrIn  (arrIn),
    .injReq (injReq),
    .steer  (steer),
    .outFlit(outFlit),
    .ejValid(ejValid),
    .ejFlit (ejOut)
  );

  assign linkOut = outFlit;
  assign ejFlit  = ejOut;
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] NODE_X = 3'd3,
  parameter logic [COORD_W-1:0] NODE_Y = 3'd4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NPORT-1:0][FLIT_W-1:0] linkIn,
  input logic                         injValid,
  input logic                         injReady,
  input logic [NPORT-1:0][FLIT_W-1:0] linkOut,
  input logic                         ejValid,
  input logic [FLIT_W-1:0]            ejFlit
);
  flit_t [NPORT-1:0] inF, outF;
  flit_t ejF;
  logic [NPORT-1:0] arrived, localArr, outValid, zeroAgeOut;
  logic [3:0] inCnt, outCnt;
  logic soloCase, localSolo;
  logic [1:0] soloPort;
  flit_t soloFlit, soloExp, localFlit;

  assign inF  = linkIn;
  assign outF = linkOut;
  assign ejF  = ejFlit;

  always_comb begin
    soloFlit = '0; localFlit = '0; soloPort = PORT_N;
    for (int i = 0; i < NPORT; i++) begin
      arrived[i]    = inF[i].hdr.valid;
      localArr[i]   = inF[i].hdr.valid && inF[i].hdr.dstX == NODE_X && inF[i].hdr.dstY == NODE_Y;
      outValid[i]   = outF[i].hdr.valid;
      zeroAgeOut[i] = outF[i].hdr.valid && (outF[i].hdr.age == '0);
      if (inF[i].hdr.valid) soloFlit = inF[i];
      if (localArr[i]) localFlit = inF[i];
    end
    if (soloFlit.hdr.dstX > NODE_X)      soloPort = PORT_E;
    else if (soloFlit.hdr.dstX < NODE_X) soloPort = PORT_W;
    else if (soloFlit.hdr.dstY > NODE_Y) soloPort = PORT_N;
    else                                 soloPort = PORT_S;
    soloExp = soloFlit;
    if (soloFlit.hdr.age != '1) soloExp.hdr.age = soloFlit.hdr.age + 1'b1;
    inCnt  = 4'($countones(arrived)) + {3'b0, injValid && injReady};
    outCnt = 4'($countones(outValid)) + {3'b0, ejValid};
    soloCase  = ($countones(arrived) == 1) && !(injValid && injReady) && (localArr == '0);
    localSolo = ($countones(localArr) == 1);
  end

  // R2
  count_conserve_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> outCnt == $past(inCnt));

  // R3
  solo_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    soloCase |=> outF[$past(soloPort)] == $past(soloExp));

  // R5
  eject_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    ejValid |-> (ejF.hdr.dstX == NODE_X && ejF.hdr.dstY == NODE_Y));

  // R5
  eject_solo_chk: assert property (@(posedge clk) disable iff (!rstN)
    localSolo |=> (ejValid && ejF == $past(localFlit)));

  // R7
  age_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |-> zeroAgeOut == '0);
endmodule

bind defl_router defl_router_chk #(.NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_chk (
  .clk(clk), .rstN(rstN), .linkIn(linkIn), .injValid(injValid), .injReady(injReady),
  .linkOut(linkOut), .ejValid(ejValid), .ejFlit(ejFlit)
);

// File: tb/defl_router_test.sv
module defl_router_test;
  import defl_pkg::*;
  localparam logic [COORD_W-1:0] NX = 3'd3;
  localparam logic [COORD_W-1:0] NY = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NPORT-1:0][FLIT_W-1:0] linkIn = '0;
  logic injValid = 1'b0;
  logic [INJ_W-1:0] injFlit = '0;
  logic injReady;
  logic [NPORT-1:0][FLIT_W-1:0] linkOut;
  logic ejValid;
  logic [FLIT_W-1:0] ejFlit;

  flit_t [NPORT-1:0] drv, outF;
  flit_t ejF;
  injReq_t injR;
  logic injV;
  int nChecks = 0;
  int nFail = 0;

  assign outF = linkOut;
  assign ejF  = ejFlit;

  always #4 clk = ~clk;

  defl_router #(.NODE_X(NX), .NODE_Y(NY)) uut (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .injValid(injValid), .injFlit(injFlit),
    .injReady(injReady), .linkOut(linkOut), .ejValid(ejValid), .ejFlit(ejFlit)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int routeOf(flit_t f);
    if (f.hdr.dstX > NX) return 1;
    if (f.hdr.dstX < NX) return 3;
    if (f.hdr.dstY > NY) return 0;
    if (f.hdr.dstY < NY) return 2;
    return 4;
  endfunction

  function automatic bit beats(flit_t a, flit_t b);
    return (a.hdr.age > b.hdr.age) || (a.hdr.age == b.hdr.age && a.hdr.src < b.hdr.src);
  endfunction

  function automatic flit_t aged(flit_t f);
    flit_t r = f;
    if (f.hdr.age != 4'hF) r.hdr.age = f.hdr.age + 4'd1;
    return r;
  endfunction

  function automatic flit_t mk(int x, int y, int src, int age, int pay);
    flit_t f;
    f.hdr.valid = 1'b1;
    f.hdr.dstX = 3'(x); f.hdr.dstY = 3'(y);
    f.hdr.src = 4'(src); f.hdr.age = 4'(age);
    f.payload = 8'(pay);
    return f;
  endfunction

  task automatic runCycle();
    flit_t expF[5];
    flit_t best, injAsFlit;
    int nExp, ejI, outCnt, bp;
    bit haveBest, tie, acc, allIn, found;
    bit used[4];
    @(negedge clk);
    linkIn = drv; injValid = injV; injFlit = injR;
    #1;
    allIn = drv[0].hdr.valid && drv[1].hdr.valid && drv[2].hdr.valid && drv[3].hdr.valid;
    check(injReady == !allIn, "R6 injReady", injReady, !allIn);
    acc = injV && !allIn;
    ejI = -1;
    for (int i = 0; i < 4; i++)
      if (drv[i].hdr.valid && routeOf(drv[i]) == 4 && (ejI < 0 || beats(drv[i], drv[ejI]))) ejI = i;
    nExp = 0; haveBest = 0; tie = 0; best = '0;
    injAsFlit.hdr.valid = 1'b1; injAsFlit.hdr.dstX = injR.hdr.dstX; injAsFlit.hdr.dstY = injR.hdr.dstY;
    injAsFlit.hdr.src = injR.hdr.src; injAsFlit.hdr.age = '0; injAsFlit.payload = injR.payload;
    for (int i = 0; i < 5; i++) begin
      flit_t f;
      if (i < 4) begin
        if (!drv[i].hdr.valid || i == ejI) continue;
        f = drv[i];
      end else begin
        if (!acc) continue;
        f = injAsFlit;
      end
      if (!haveBest || beats(f, best)) begin best = f; haveBest = 1; tie = 0; end
      else if (!beats(best, f)) tie = 1;
      expF[nExp] = aged(f);
      nExp++;
    end
    @(posedge clk);
    #1;
    outCnt = 0;
    for (int p = 0; p < 4; p++) begin
      used[p] = 0;
      if (outF[p].hdr.valid) outCnt++;
    end
    check(outCnt + int'(ejValid) == nExp + int'(ejI >= 0), "R2 flit count",
          outCnt + int'(ejValid), nExp + int'(ejI >= 0));
    for (int e = 0; e < nExp; e++) begin
      found = 0;
      for (int p = 0; p < 4; p++)
        if (!found && !used[p] && outF[p] == expF[e]) begin used[p] = 1; found = 1; end
      check(found, "R8 flit leaves intact (R7 aged)", 0, expF[e]);
    end
    check(ejValid == (ejI >= 0), "R5 eject valid", ejValid, ejI >= 0);
    if (ejI >= 0) check(ejF == drv[ejI], "R5 ejected flit", ejF, drv[ejI]);
    if (haveBest && !tie && routeOf(best) != 4) begin
      bp = routeOf(best);
      check(outF[bp].hdr.valid && outF[bp].payload == best.payload, "R4 oldest gets port",
            outF[bp].payload, best.payload);
    end
    if (acc) begin
      found = 0;
      for (int p = 0; p < 4; p++)
        if (outF[p].hdr.valid && outF[p].payload == injR.payload && outF[p].hdr.age == 4'd1) found = 1;
      check(found, "R6 injected flit out with age 1", 0, injR.payload);
    end
  endtask

  task automatic clearDrive();
    drv = '0; injV = 0; injR = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int tx[5];
    int ty[5];
    void'($urandom(32'd7731));
    clearDrive();
    // R1: reset with busy inputs
    linkIn[0] = mk(5, 4, 1, 2, 8'h10);
    linkIn[2] = mk(3, 4, 2, 3, 8'h12);
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 4; p++) check(!outF[p].hdr.valid, "R1 link out idle in reset", outF[p].hdr.valid, 0);
    check(!ejValid, "R1 eject idle in reset", ejValid, 0);
    @(negedge clk); rstN = 1'b1; linkIn = '0;

    // R3: lone flits toward each direction, X before Y
    tx = '{5, 1, 3, 3, 6}; ty = '{4, 4, 7, 0, 0};
    for (int t = 0; t < 5; t++) begin
      int ep;
      clearDrive();
      drv[t % 4] = mk(tx[t], ty[t], 3, 5, 8'h20 + t);
      runCycle();
      ep = (t == 0 || t == 4) ? 1 : (t == 1) ? 3 : (t == 2) ? 0 : 2;
      check(outF[ep].hdr.valid && outF[ep].payload == 8'(8'h20 + t), "R3 X-first port",
            outF[ep].payload, 8'h20 + t);
    end

    // R4: two flits contend for east; older one wins
    clearDrive();
    drv[0] = mk(6, 1, 2, 3, 8'h31);
    drv[1] = mk(7, 4, 9, 9, 8'h32);
    runCycle();
    check(outF[1].payload == 8'h32, "R4 older takes east", outF[1].payload, 8'h32);
    // R4: equal age, lower source wins
    drv[0] = mk(6, 1, 2, 9, 8'h33);
    runCycle();
    check(outF[1].payload == 8'h33, "R4 lower source takes east", outF[1].payload, 8'h33);

    // R5: four local flits, one ejected and three deflected
    clearDrive();
    for (int i = 0; i < 4; i++) drv[i] = mk(3, 4, i, 4 + (i == 2 ? 5 : 0), 8'h40 + i);
    runCycle();
    check(ejValid && ejF.payload == 8'h42, "R5 oldest local ejected", ejF.payload, 8'h42);

    // R6: full inputs refuse injection
    clearDrive();
    for (int i = 0; i < 4; i++) drv[i] = mk(i, 2 * i, i, 1, 8'h50 + i);
    injV = 1; injR = '{hdr: '{dstX: 3'd0, dstY: 3'd0, src: 4'd7}, payload: 8'h54};
    runCycle();
    check(!injReady, "R6 ready low at four arrivals", injReady, 0);

    // R7: age saturation
    clearDrive();
    drv[3] = mk(0, 0, 1, 15, 8'h60);
    drv[1] = mk(3, 7, 2, 14, 8'h61);
    runCycle();
    check(outF[3].hdr.age == 4'd15, "R7 age holds at 15", outF[3].hdr.age, 15);
    check(outF[0].hdr.age == 4'd15, "R7 age 14 becomes 15", outF[0].hdr.age, 15);

    // random traffic
    for (int c = 0; c < 1500; c++) begin
      clearDrive();
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(0, 9) < 6) begin
          if ($urandom_range(0, 3) == 0) drv[i] = mk(NX, NY, $urandom_range(0, 15), $urandom_range(0, 15), 0);
          else drv[i] = mk($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 15),
                           $urandom_range(0, 15), 0);
          drv[i].payload = 8'({$urandom_range(0, 31), 3'(i)});
        end
      end
      injV = ($urandom_range(0, 1) == 1);
      injR.hdr.dstX = 3'($urandom_range(0, 7));
      injR.hdr.dstY = 3'($urandom_range(0, 7));
      injR.hdr.src  = 4'($urandom_range(0, 15));
      injR.payload  = 8'({$urandom_range(0, 31), 3'd4});
      runCycle();
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule